// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that measures time against an external free-running 64-bit system count. Software programs an interval, enables the timer, and must refresh it before the count reaches an absolute deadline. When the first deadline passes unrefreshed, the block raises a warning stage that drives a level interrupt and sets a new deadline one interval later. When that second deadline also passes, it raises a bite stage that drives a level reset request to the system reset logic.

Two register windows are exposed, each through a single-cycle port with a write strobe and a combinational read. The refresh window holds only a kick register and an identification word. The control window holds the control/status word, the interval register and the deadline register. Any write to the kick register, the control/status word or the interval register counts as a refresh. The bite flag is kept on a power-on reset that is separate from the system reset it requests, so software can find out after a reboot that the watchdog caused it.

A four-state machine tracks the timer: `ST_OFF` (disabled), `ST_WATCH` (armed, first interval), `ST_WARN` (warning raised, second interval) and `ST_BITE` (reset requested). The transitions are:

- Arm: `ST_OFF` moves to `ST_WATCH` on a refresh with enable set.
- Warn: `ST_WATCH` moves to `ST_WARN` on expiry.
- Bite: `ST_WARN` moves to `ST_BITE` on expiry.
- Kick: any armed state returns to `ST_WATCH` on a refresh with enable set.
- Stop: any state moves to `ST_OFF` on a refresh with enable clear.

Top module: `wdg_two_stage`

## Requirements
- R1: After power-on reset, the control/status word reads 0 and both outputs are low. The identification word reads at 0xFCC in both windows, with bits [19:16] equal to the VERSION parameter and bits [11:0] equal to IMPL_CODE. Other refresh-window addresses read 0.
- R2: A write of any data to refresh-window address 0x000 is a refresh. A refresh loads the deadline with system count plus interval, clears both stages, and leaves the timer armed if enable is set.
- R3: The control/status word is at control address 0x000, with bit 0 = enable, bit 1 = warning stage and bit 2 = bite stage. A write sets enable from data bit 0 and is a refresh. Data bits 1 and 2 are ignored.
- R4: While armed in the first interval, a system count at or above the deadline sets the warning stage on the next edge and reloads the deadline with count plus interval.
- R5: While the warning stage is set, a system count at or above the deadline sets the bite stage on the next edge.
- R6: With enable clear, neither stage asserts, whatever the count does. Writing 0 to the control/status word stops the timer.
- R7: The interrupt output follows the warning stage as a level. The reset-request output follows the bite stage as a level.
- R8: The bite stage survives the system reset input and is cleared only by a refresh or by the power-on reset input. The system reset clears enable, the warning stage and the interval.
- R9: The interval is at control addresses 0x008 (low word) and 0x00C (high word). For VERSION 1 it is 48 bits wide: a high-word write keeps only data bits [15:0], and bits [63:48] read 0. For VERSION 0 it is 32 bits wide, and 0x00C reads 0 and ignores writes. A write to an implemented interval word is a refresh that uses the new interval.
- R10: The deadline is at control addresses 0x010 (low) and 0x014 (high) and reads its live value. A low-word write is held in a staging register. A high-word write commits high and staged low together, and the new value is used for the next comparison.
- R11: A refresh in the same cycle as an expiry takes priority: no stage is raised and the deadline is loaded from the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the bite stage |
| sys_count | input | 64 | Free-running system count |
| rf_wr | input | 1 | Refresh-window write strobe |
| rf_addr | input | ADDR_W | Refresh-window byte address |
| rf_wdata | input | 32 | Refresh-window write data |
| rf_rdata | output | 32 | Refresh-window read data (combinational) |
| cf_wr | input | 1 | Control-window write strobe |
| cf_addr | input | ADDR_W | Control-window byte address |
| cf_wdata | input | 32 | Control-window write data |
| cf_rdata | output | 32 | Control-window read data (combinational) |
| wd_irq | output | 1 | Level interrupt from the warning stage |
| wd_reset_req | output | 1 | Level reset request from the bite stage |

## Verification
The assertions assume that the system count only moves forward, that the two write ports carry single-cycle strobes, and that both resets are released away from a write. The stimulus drives the count to chosen values that never decrease. It changes strobes, addresses and resets only at falling edges, with one write per call. It places the count exactly one below and exactly at each deadline, and it lines a refresh up with an expiry in the same cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_WARN  = 2'd2,
        ST_BITE  = 2'd3
    } wd_state_e;

    localparam int unsigned A_KICK    = 'h000;
    localparam int unsigned A_CTRL    = 'h000;
    localparam int unsigned A_IVL_LO  = 'h008;
    localparam int unsigned A_IVL_HI  = 'h00C;
    localparam int unsigned A_DL_LO   = 'h010;
    localparam int unsigned A_DL_HI   = 'h014;
    localparam int unsigned A_IDENT   = 'hFCC;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_WARN_BIT = 1;
    localparam int unsigned CTRL_BITE_BIT = 2;

    function automatic int unsigned ivl_width(input int unsigned version);
        return (version >= 1) ? 48 : 32;
    endfunction

endpackage

// File: rtl/wdg_interval.sv
module wdg_interval #(
    parameter int unsigned VERSION = 1
) (
    input  logic        clk,
    input  logic        core_rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] ivl_q,
    output logic [63:0] ivl_next
);
    import wdg_pkg::*;

    localparam int unsigned IVL_W = ivl_width(VERSION);

    logic [31:0] lo_q;
    logic [31:0] lo_d;

    always_comb begin
        lo_d = wr_lo ? wdata : lo_q;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            lo_q <= '0;
        end else begin
            lo_q <= lo_d;
        end
    end

    generate
        if (IVL_W > 32) begin : g_wide
            localparam int unsigned HI_W = IVL_W - 32;
            logic [HI_W-1:0] hi_q;
            logic [HI_W-1:0] hi_d;

            always_comb begin
                hi_d = wr_hi ? wdata[HI_W-1:0] : hi_q;
            end

            always_ff @(posedge clk or negedge core_rst_n) begin
                if (!core_rst_n) begin
                    hi_q <= '0;
                end else begin
                    hi_q <= hi_d;
                end
            end

            assign ivl_q    = {{(64-IVL_W){1'b0}}, hi_q, lo_q};
            assign ivl_next = {{(64-IVL_W){1'b0}}, hi_d, lo_d};

            a_r9_upper_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
                wr_hi |=> (ivl_q[63:32] == {{(64-IVL_W){1'b0}}, $past(wdata[HI_W-1:0])}));
        end else begin : g_narrow
            assign ivl_q    = {32'd0, lo_q};
            assign ivl_next = {32'd0, lo_d};
        end
    endgenerate

endmodule

// File: rtl/wdg_deadline.sv
module wdg_deadline (
    input  logic        clk,
    input  logic        core_rst_n,
    input  logic        refresh,
    input  logic        stage_reload,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic [63:0] sys_count,
    input  logic [63:0] ivl_next,
    output logic [63:0] dl_q,
    output logic        expired
);
    logic [31:0] stage_lo_q;
    logic [63:0] dl_d;
    logic [63:0] reload_val;

    always_comb begin
        reload_val = sys_count + ivl_next;
        if (refresh || stage_reload) begin
            dl_d = reload_val;
        end else if (wr_hi) begin
            dl_d = {wdata, stage_lo_q};
        end else begin
            dl_d = dl_q;
        end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            dl_q       <= '0;
            stage_lo_q <= '0;
        end else begin
            dl_q <= dl_d;
            if (wr_lo) begin
                stage_lo_q <= wdata;
            end
        end
    end

    assign expired = (sys_count >= dl_q);

    a_r10_high_commit: assert property (@(posedge clk) disable iff (!core_rst_n)
        (wr_hi && !refresh && !stage_reload) |=> (dl_q[63:32] == $past(wdata)));

endmodule

// File: rtl/wdg_stage_fsm.sv
module wdg_stage_fsm (
    input  logic clk,
    input  logic por_n,
    input  logic core_rst_n,
    input  logic refresh,
    input  logic en_next,
    input  logic expired,
    output logic ws0,
    output logic ws1,
    output logic stage_reload
);
    import wdg_pkg::*;

    wd_state_e state_q;
    wd_state_e state_d;
    logic      bite_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (refresh && en_next) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (refresh)      state_d = en_next ? ST_WATCH : ST_OFF;
                else if (expired) state_d = ST_WARN;
            end
            ST_WARN: begin
                if (refresh)      state_d = en_next ? ST_WATCH : ST_OFF;
                else if (expired) state_d = ST_BITE;
            end
            ST_BITE: begin
                if (refresh)      state_d = en_next ? ST_WATCH : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Bite flag lives on the power-on domain only.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bite_q <= 1'b0;
        end else if (core_rst_n) begin
            if (refresh) begin
                bite_q <= 1'b0;
            end else if (state_q == ST_WARN && expired) begin
                bite_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ws0          = (state_q == ST_WARN) || (state_q == ST_BITE);
        ws1          = bite_q;
        stage_reload = (state_q == ST_WATCH) && expired && !refresh;
    end

    a_r5_bite_after_warn: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        $rose(ws1) |-> $past(ws0));

    a_r2_refresh_clears: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        refresh |=> (!ws0 && !ws1));

endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage #(
    parameter int unsigned VERSION   = 1,
    parameter int unsigned IMPL_CODE = 'h0A5,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [63:0]       sys_count,
    input  logic              rf_wr,
    input  logic [ADDR_W-1:0] rf_addr,
    input  logic [31:0]       rf_wdata,
    output logic [31:0]       rf_rdata,
    input  logic              cf_wr,
    input  logic [ADDR_W-1:0] cf_addr,
    input  logic [31:0]       cf_wdata,
    output logic [31:0]       cf_rdata,
    output logic              wd_irq,
    output logic              wd_reset_req
);
    import wdg_pkg::*;

    localparam int unsigned IVL_W    = ivl_width(VERSION);
    localparam logic [31:0] IDENT_WD = {12'd0, 4'(VERSION), 4'd0, 12'(IMPL_CODE)};

    logic        core_rst_n;
    logic        en_q;
    logic        en_next;
    logic        kick_wr;
    logic        ctrl_wr;
    logic        ivl_lo_wr;
    logic        ivl_hi_wr;
    logic        dl_lo_wr;
    logic        dl_hi_wr;
    logic        refresh;
    logic [63:0] ivl_q;
    logic [63:0] ivl_next;
    logic [63:0] dl_q;
    logic        expired;
    logic        ws0;
    logic        ws1;
    logic        stage_reload;
    logic        rf_unused;

    assign core_rst_n = por_n & sys_rst_n;
    assign rf_unused  = ^rf_wdata;

    always_comb begin
        kick_wr   = rf_wr && (rf_addr == ADDR_W'(A_KICK));
        ctrl_wr   = cf_wr && (cf_addr == ADDR_W'(A_CTRL));
        ivl_lo_wr = cf_wr && (cf_addr == ADDR_W'(A_IVL_LO));
        ivl_hi_wr = cf_wr && (cf_addr == ADDR_W'(A_IVL_HI)) && (IVL_W > 32);
        dl_lo_wr  = cf_wr && (cf_addr == ADDR_W'(A_DL_LO));
        dl_hi_wr  = cf_wr && (cf_addr == ADDR_W'(A_DL_HI));
        refresh   = kick_wr || ctrl_wr || ivl_lo_wr || ivl_hi_wr;
        en_next   = ctrl_wr ? cf_wdata[CTRL_EN_BIT] : en_q;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_next;
        end
    end

    wdg_interval #(.VERSION(VERSION)) u_ivl (
        .clk        (clk),
        .core_rst_n (core_rst_n),
        .wr_lo      (ivl_lo_wr),
        .wr_hi      (ivl_hi_wr),
        .wdata      (cf_wdata),
        .ivl_q      (ivl_q),
        .ivl_next   (ivl_next)
    );

    wdg_deadline u_dl (
        .clk          (clk),
        .core_rst_n   (core_rst_n),
        .refresh      (refresh),
        .stage_reload (stage_reload),
        .wr_lo        (dl_lo_wr),
        .wr_hi        (dl_hi_wr),
        .wdata        (cf_wdata),
        .sys_count    (sys_count),
        .ivl_next     (ivl_next),
        .dl_q         (dl_q),
        .expired      (expired)
    );

    wdg_stage_fsm u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .core_rst_n   (core_rst_n),
        .refresh      (refresh),
        .en_next      (en_next),
        .expired      (expired),
        .ws0          (ws0),
        .ws1          (ws1),
        .stage_reload (stage_reload)
    );

    // Read paths, one per window.
    always_comb begin
        rf_rdata = 32'd0;
        if (rf_addr == ADDR_W'(A_IDENT)) rf_rdata = IDENT_WD;
    end

    always_comb begin
        cf_rdata = 32'd0;
        unique case (cf_addr)
            ADDR_W'(A_CTRL): begin
                cf_rdata[CTRL_EN_BIT]   = en_q;
                cf_rdata[CTRL_WARN_BIT] = ws0;
                cf_rdata[CTRL_BITE_BIT] = ws1;
            end
            ADDR_W'(A_IVL_LO): cf_rdata = ivl_q[31:0];
            ADDR_W'(A_IVL_HI): cf_rdata = ivl_q[63:32];
            ADDR_W'(A_DL_LO):  cf_rdata = dl_q[31:0];
            ADDR_W'(A_DL_HI):  cf_rdata = dl_q[63:32];
            ADDR_W'(A_IDENT):  cf_rdata = IDENT_WD;
            default:           cf_rdata = 32'd0;
        endcase
    end

    always_comb begin
        wd_irq       = ws0;
        wd_reset_req = ws1;
    end

    a_r4_warn_reload: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(ws0) |-> (dl_q == $past(sys_count) + $past(ivl_next)));

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!core_rst_n)
        !en_q |=> !$rose(ws0));

    a_r11_refresh_wins: assert property (@(posedge clk) disable iff (!core_rst_n)
        (refresh && expired) |=> !ws0);

endmodule

// File: tb/wdg_two_stage_test.sv
module wdg_two_stage_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic [63:0] sys_count = 64'd0;
    logic        rf_wr = 1'b0;
    logic [11:0] rf_addr = 12'd0;
    logic [31:0] rf_wdata = 32'd0;
    logic [31:0] rf_rdata;
    logic        cf_wr = 1'b0;
    logic [11:0] cf_addr = 12'd0;
    logic [31:0] cf_wdata = 32'd0;
    logic [31:0] cf_rdata;
    logic        wd_irq;
    logic        wd_reset_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdg_two_stage uut (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_n    (sys_rst_n),
        .sys_count    (sys_count),
        .rf_wr        (rf_wr),
        .rf_addr      (rf_addr),
        .rf_wdata     (rf_wdata),
        .rf_rdata     (rf_rdata),
        .cf_wr        (cf_wr),
        .cf_addr      (cf_addr),
        .cf_wdata     (cf_wdata),
        .cf_rdata     (cf_rdata),
        .wd_irq       (wd_irq),
        .wd_reset_req (wd_reset_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
        cf_addr = a; cf_wdata = d; cf_wr = 1'b1;
        @(negedge clk);
        cf_wr = 1'b0;
    endtask

    task automatic rf_write(input logic [11:0] a, input logic [31:0] d);
        rf_addr = a; rf_wdata = d; rf_wr = 1'b1;
        @(negedge clk);
        rf_wr = 1'b0;
    endtask

    task automatic cf_read(input logic [11:0] a, output logic [31:0] d);
        cf_addr = a; #1; d = cf_rdata;
    endtask

    task automatic rf_read(input logic [11:0] a, output logic [31:0] d);
        rf_addr = a; #1; d = rf_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        cf_read(12'h000, v); check("R1 ctrl after por", v, 0);
        check("R1 irq low", wd_irq, 0);
        check("R1 reset_req low", wd_reset_req, 0);
        cf_read(12'hFCC, v); check("R1 ident ctrl", v, 32'h0001_00A5);
        rf_read(12'hFCC, v); check("R1 ident refresh", v, 32'h0001_00A5);
        rf_read(12'h000, v); check("R1 kick reads 0", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        sys_count = 64'd1000;
        cf_write(12'h008, 32'd100);
        cf_write(12'h000, 32'h1);
        cf_read(12'h000, v); check("R3 enable set", v, 1);
        cf_read(12'h010, v); check("R2 deadline after enable", v, 1100);
    endtask

    task automatic t_stages();
        logic [31:0] v;
        sys_count = 64'd1099; step();
        cf_read(12'h000, v); check("R4 no warn before deadline", v, 1);
        check("R7 irq low before deadline", wd_irq, 0);
        sys_count = 64'd1100; step();
        cf_read(12'h000, v); check("R4 warn at deadline", v, 3);
        check("R7 irq follows warn", wd_irq, 1);
        cf_read(12'h010, v); check("R4 deadline reloaded", v, 1200);
        sys_count = 64'd1199; step();
        check("R5 no bite early", wd_reset_req, 0);
        sys_count = 64'd1200; step();
        cf_read(12'h000, v); check("R5 bite at second deadline", v, 7);
        check("R7 reset_req follows bite", wd_reset_req, 1);
    endtask

    task automatic t_kick();
        logic [31:0] v;
        sys_count = 64'd1300;
        rf_write(12'h000, 32'hDEAD_BEEF);
        cf_read(12'h000, v); check("R2 kick clears stages", v, 1);
        check("R2 irq cleared", wd_irq, 0);
        check("R2 reset_req cleared", wd_reset_req, 0);
        cf_read(12'h010, v); check("R2 kick reload", v, 1400);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        sys_count = 64'd1400;
        rf_write(12'h000, 32'h0);
        cf_read(12'h000, v); check("R11 refresh beats expiry", v, 1);
        cf_read(12'h010, v); check("R11 deadline from refresh", v, 1500);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        cf_write(12'h000, 32'h6);
        cf_read(12'h000, v); check("R3 stage bits ignored on write", v, 0);
        sys_count = 64'd2000; step(); step(); step();
        cf_read(12'h000, v); check("R6 disabled no stage", v, 0);
        check("R6 irq quiet when disabled", wd_irq, 0);
        cf_write(12'h000, 32'h7);
        cf_read(12'h000, v); check("R3 reenable only enable bit", v, 1);
        cf_read(12'h010, v); check("R3 ctrl write refreshes", v, 2100);
    endtask

    task automatic t_interval_width();
        logic [31:0] v;
        cf_write(12'h00C, 32'hFFFF_0002);
        cf_read(12'h00C, v); check("R9 high word keeps 16 bits", v, 2);
        cf_read(12'h014, v); check("R9 refresh with new interval hi", v, 2);
        cf_read(12'h010, v); check("R9 refresh with new interval lo", v, 2100);
        cf_write(12'h00C, 32'h0);
        cf_read(12'h014, v); check("R9 restore hi", v, 0);
    endtask

    task automatic t_deadline_write();
        logic [31:0] v;
        cf_write(12'h010, 32'd5000);
        cf_read(12'h010, v); check("R10 low write staged", v, 2100);
        cf_write(12'h014, 32'd0);
        cf_read(12'h010, v); check("R10 commit on high write", v, 5000);
        sys_count = 64'd4999; step();
        cf_read(12'h000, v); check("R10 no warn before new deadline", v, 1);
        sys_count = 64'd5000; step();
        cf_read(12'h000, v); check("R10 warn at written deadline", v, 3);
        sys_count = 64'd5100; step();
        check("R5 bite again", wd_reset_req, 1);
    endtask

    task automatic t_persist();
        logic [31:0] v;
        sys_rst_n = 1'b0; step(); sys_rst_n = 1'b1; step();
        cf_read(12'h000, v); check("R8 bite survives system reset", v, 4);
        check("R8 reset_req held", wd_reset_req, 1);
        check("R8 irq cleared by system reset", wd_irq, 0);
        cf_read(12'h008, v); check("R8 interval cleared", v, 0);
        por_n = 1'b0; step(); por_n = 1'b1; step();
        cf_read(12'h000, v); check("R8 por clears bite", v, 0);
        check("R8 reset_req low after por", wd_reset_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_stages();
        t_kick();
        t_same_cycle();
        t_disable();
        t_interval_width();
        t_deadline_write();
        t_persist();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule